// File: doc/BRIEF.md
# Pipelined Shift-and-Add Vector Rotator

This block turns a signed two-dimensional vector (x, y) counter-clockwise by an angle given as an unsigned phase word. No multipliers are used. A coarse step first turns the vector by a whole number of quarter turns, so that at most one eighth of a turn is left over. After that, a chain of registered micro-rotation stages works the leftover angle down toward zero. Stage k turns the vector by plus or minus atan(2^-k). It picks the direction from the sign of the residual angle it receives.

Typical uses are a frequency shifter, where a sample stream is rotated by the output of a phase accumulator, and a sine/cosine source, where a constant vector (A, 0) is fed in. The result carries the fixed micro-rotation gain of about 1.647, which is not compensated. The internal words carry guard bits, so this gain and the quarter-turn step cannot overflow. One new sample can enter on every clock. A strobe travels down the pipeline beside the data and marks which output words are real.

Top module: `cordic_rotator`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, o_valid is low. During reset, o_x and o_y read zero.
- R2: A sample presented with i_stb high appears on o_x/o_y with o_valid high exactly NSTG+1 clock cycles later.
- R3: i_phase is unsigned. A full turn is 2^PW, and a positive phase rotates counter-clockwise. The output equals G*(x*cos(t) - y*sin(t), x*sin(t) + y*cos(t)) to within 32 LSB, where G is the product of sqrt(1+2^-2k) over the stages.
- R4: The coarse step picks the quarter turn nearest to the phase, with a tie at exactly one eighth resolved upward. The residual angle it hands on lies in [-1/8, +1/8) of a turn.
- R5: Stage k subtracts its angle from the residual when the residual is non-negative and adds it otherwise. The final residual is no larger than the last stage's angle plus rounding.
- R6: With phase 0, an input (A, 0) gives about (1.647*A, 0) at the output.
- R7: Phases of exactly 0, 1/4, 1/2 and 3/4 turn give the gain-scaled input, rotated by the matching quarter turn.
- R8: Inputs at full scale in both components, including -2^(IW-1), produce correct, non-wrapped results at any phase.
- R9: Samples presented on consecutive cycles come out on consecutive cycles, in the same order.
- R10: Cycles with i_stb low produce no o_valid pulse. Gaps in the input stream reappear unchanged at the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_stb | input | 1 | Sample strobe: inputs are valid this cycle |
| i_x | input | IW | Signed x component |
| i_y | input | IW | Signed y component |
| i_phase | input | PW | Rotation angle, 2^PW per full turn |
| o_valid | output | 1 | Output sample strobe |
| o_x | output | IW+GUARD | Signed rotated x, gain about 1.647 |
| o_y | output | IW+GUARD | Signed rotated y, gain about 1.647 |

## Verification
The bench drives phases on and next to the quarter-turn and eighth-turn boundaries. These are the points where a wrong rounding or a swapped quadrant case shows up. Such an error gives a vector pointing 90 or 180 degrees away from the expected one, and in the gain test the x and y results would come out exchanged. Full-scale inputs of -32768 catch a missing guard bit, which would show up as a sign wrap giving a huge error. A sweep of phases catches a reversed stage direction or a wrong angle constant, either of which leaves the angle off by degrees. Back-to-back samples with gaps catch a strobe that is delayed by the wrong number of stages, or one that is dropped or repeated.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    // Value of pi used for phase scaling at elaboration time.
    localparam real PI_R = 3.14159265358979323846;

    // atan(2^-k) in radians, computed by power series for k >= 1.
    // For k = 0 the exact value pi/4 is returned.
    function automatic real atan_pow2(input int k);
        real t;
        real term;
        real acc;
        if (k == 0) return PI_R / 4.0;
        t    = 1.0;
        for (int i = 0; i < k; i++) t = t / 2.0;
        acc  = 0.0;
        term = t;
        for (int n = 0; n < 40; n++) begin
            if ((n % 2) == 0) acc = acc + term / real'(2 * n + 1);
            else              acc = acc - term / real'(2 * n + 1);
            term = term * t * t;
        end
        return acc;
    endfunction

    // Micro-rotation angle of stage k, in units of 2^zw per full turn.
    function automatic longint stage_angle(input int k, input int zw);
        real scale;
        scale = 1.0;
        for (int i = 0; i < zw; i++) scale = scale * 2.0;
        return longint'(atan_pow2(k) / (2.0 * PI_R) * scale);
    endfunction

endpackage

// File: rtl/cordic_prerot.sv
module cordic_prerot #(
    parameter int IW = 16,
    parameter int WW = 18,
    parameter int PW = 16,
    parameter int ZW = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 i_stb,
    input  logic signed [IW-1:0] i_x,
    input  logic signed [IW-1:0] i_y,
    input  logic        [PW-1:0] i_phase,
    output logic                 o_vld,
    output logic signed [WW-1:0] o_x,
    output logic signed [WW-1:0] o_y,
    output logic signed [ZW-1:0] o_z
);
    localparam logic [PW-1:0] EIGHTH = {3'b001, {(PW-3){1'b0}}};

    typedef struct packed {
        logic          vld;
        logic [WW-1:0] x;
        logic [WW-1:0] y;
        logic [ZW-1:0] z;
    } pre_t;

    pre_t pre_d, pre_q;

    logic [PW-1:0]        ph_rnd;
    logic [1:0]           quad;
    logic [PW-1:0]        resid;
    logic signed [WW-1:0] xe;
    logic signed [WW-1:0] ye;

    always_comb begin
        ph_rnd = i_phase + EIGHTH;
        quad   = ph_rnd[PW-1:PW-2];
        resid  = i_phase - {quad, {(PW-2){1'b0}}};
        xe     = {{(WW-IW){i_x[IW-1]}}, i_x};
        ye     = {{(WW-IW){i_y[IW-1]}}, i_y};

        pre_d.vld = i_stb;
        pre_d.z   = {resid, {(ZW-PW){1'b0}}};
        unique case (quad)
            2'd0: begin pre_d.x = xe;  pre_d.y = ye;  end
            2'd1: begin pre_d.x = -ye; pre_d.y = xe;  end
            2'd2: begin pre_d.x = -xe; pre_d.y = -ye; end
            default: begin pre_d.x = ye; pre_d.y = -xe; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign o_vld = pre_q.vld;
    assign o_x   = pre_q.x;
    assign o_y   = pre_q.y;
    assign o_z   = pre_q.z;

endmodule

// File: rtl/cordic_stage.sv
module cordic_stage #(
    parameter int WW = 18,
    parameter int ZW = 20,
    parameter int K  = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 i_vld,
    input  logic signed [WW-1:0] i_x,
    input  logic signed [WW-1:0] i_y,
    input  logic signed [ZW-1:0] i_z,
    output logic                 o_vld,
    output logic signed [WW-1:0] o_x,
    output logic signed [WW-1:0] o_y,
    output logic signed [ZW-1:0] o_z
);
    localparam longint ANG_L = cordic_pkg::stage_angle(K, ZW);
    localparam logic signed [ZW-1:0] ANG = ANG_L[ZW-1:0];

    typedef struct packed {
        logic          vld;
        logic [WW-1:0] x;
        logic [WW-1:0] y;
        logic [ZW-1:0] z;
    } stg_t;

    stg_t stg_d, stg_q;

    logic signed [WW-1:0] x_sh;
    logic signed [WW-1:0] y_sh;

    always_comb begin
        x_sh      = i_x >>> K;
        y_sh      = i_y >>> K;
        stg_d.vld = i_vld;
        if (!i_z[ZW-1]) begin
            stg_d.x = i_x - y_sh;
            stg_d.y = i_y + x_sh;
            stg_d.z = i_z - ANG;
        end else begin
            stg_d.x = i_x + y_sh;
            stg_d.y = i_y - x_sh;
            stg_d.z = i_z + ANG;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign o_vld = stg_q.vld;
    assign o_x   = stg_q.x;
    assign o_y   = stg_q.y;
    assign o_z   = stg_q.z;

endmodule

// File: rtl/cordic_rotator.sv
module cordic_rotator #(
    parameter int IW     = 16,
    parameter int PW     = 16,
    parameter int NSTG   = 16,
    parameter int GUARD  = 2,
    parameter int ZGUARD = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       i_stb,
    input  logic signed [IW-1:0]       i_x,
    input  logic signed [IW-1:0]       i_y,
    input  logic        [PW-1:0]       i_phase,
    output logic                       o_valid,
    output logic signed [IW+GUARD-1:0] o_x,
    output logic signed [IW+GUARD-1:0] o_y
);
    localparam int WW = IW + GUARD;
    localparam int ZW = PW + ZGUARD;

    logic                 sv [0:NSTG];
    logic signed [WW-1:0] sx [0:NSTG];
    logic signed [WW-1:0] sy [0:NSTG];
    logic signed [ZW-1:0] sz [0:NSTG];

    cordic_prerot #(.IW(IW), .WW(WW), .PW(PW), .ZW(ZW)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .i_stb   (i_stb),
        .i_x     (i_x),
        .i_y     (i_y),
        .i_phase (i_phase),
        .o_vld   (sv[0]),
        .o_x     (sx[0]),
        .o_y     (sy[0]),
        .o_z     (sz[0])
    );

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        cordic_stage #(.WW(WW), .ZW(ZW), .K(g)) u_stg (
            .clk   (clk),
            .rst_n (rst_n),
            .i_vld (sv[g]),
            .i_x   (sx[g]),
            .i_y   (sy[g]),
            .i_z   (sz[g]),
            .o_vld (sv[g+1]),
            .o_x   (sx[g+1]),
            .o_y   (sy[g+1]),
            .o_z   (sz[g+1])
        );
    end

    assign o_valid = sv[NSTG];
    assign o_x     = sx[NSTG];
    assign o_y     = sy[NSTG];

endmodule

// File: rtl/cordic_rotator_chk.sv
module cordic_rotator_chk #(
    parameter int NSTG = 16,
    parameter int ZW   = 20
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 i_stb,
    input logic                 o_valid,
    input logic                 vld [0:NSTG],
    input logic signed [ZW-1:0] z_first,
    input logic signed [ZW-1:0] z_last
);
    localparam int QLIM = 1 << (ZW - 3);
    localparam int ZLIM = int'(cordic_pkg::stage_angle(NSTG - 1, ZW)) + 2 * NSTG;

    // R1
    out_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !o_valid);

    // R2
    stb_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (vld[0] == $past(i_stb)));

    for (genvar g = 0; g < NSTG; g++) begin : g_step
        // R2
        vld_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (vld[g+1] == $past(vld[g])));
    end

    // R4
    resid_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld[0] |-> ((z_first >= -QLIM) && (z_first < QLIM)));

    // R5
    resid_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld[NSTG] |-> ((z_last <= ZLIM) && (z_last >= -ZLIM)));

endmodule

bind cordic_rotator cordic_rotator_chk #(.NSTG(NSTG), .ZW(ZW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .i_stb   (i_stb),
    .o_valid (o_valid),
    .vld     (sv),
    .z_first (sz[0]),
    .z_last  (sz[NSTG])
);

// File: tb/cordic_rotator_tb.sv
module cordic_rotator_tb;
    localparam int  IW   = 16;
    localparam int  PW   = 16;
    localparam int  NSTG = 16;
    localparam int  WW   = IW + 2;
    localparam int  LAT  = NSTG + 1;
    localparam real TOL  = 32.0;
    localparam real PI_R = 3.14159265358979323846;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 i_stb = 1'b0;
    logic signed [IW-1:0] i_x = '0;
    logic signed [IW-1:0] i_y = '0;
    logic        [PW-1:0] i_phase = '0;
    logic                 o_valid;
    logic signed [WW-1:0] o_x;
    logic signed [WW-1:0] o_y;

    cordic_rotator #(.IW(IW), .PW(PW), .NSTG(NSTG)) u_dut (
        .clk(clk), .rst_n(rst_n), .i_stb(i_stb), .i_x(i_x), .i_y(i_y),
        .i_phase(i_phase), .o_valid(o_valid), .o_x(o_x), .o_y(o_y)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    real   gain = 1.0;
    real   ex_q[$];
    real   ey_q[$];
    int    ec_q[$];
    string tag_q[$];

    task automatic check(input string req, input bit ok, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %s expected %s", req, act, exp);
        end
    endtask

    // Output monitor: compares every valid output with the oldest expected sample.
    always @(negedge clk) begin
        if (rst_n && o_valid && !done) begin
            if (ex_q.size() == 0) begin
                check("R10", 1'b0, "o_valid=1", "no output pending");
            end else begin
                real   ex, ey;
                int    ec;
                string tg;
                ex = ex_q.pop_front();
                ey = ey_q.pop_front();
                ec = ec_q.pop_front();
                tg = tag_q.pop_front();
                check({tg, " x"}, ($itor(o_x) - ex <= TOL) && (ex - $itor(o_x) <= TOL),
                      $sformatf("%0d", o_x), $sformatf("%0.1f", ex));
                check({tg, " y"}, ($itor(o_y) - ey <= TOL) && (ey - $itor(o_y) <= TOL),
                      $sformatf("%0d", o_y), $sformatf("%0.1f", ey));
                // R2 / R9: latency of every sample
                check("R2 latency", (cyc - ec) == LAT,
                      $sformatf("%0d", cyc - ec), $sformatf("%0d", LAT));
            end
        end
    end

    task automatic send(input int x, input int y, input int ph, input string tg);
        real th;
        @(negedge clk);
        i_stb   = 1'b1;
        i_x     = IW'(x);
        i_y     = IW'(y);
        i_phase = PW'(ph);
        th = real'(ph) * 2.0 * PI_R / 65536.0;
        ex_q.push_back(gain * (real'(x) * $cos(th) - real'(y) * $sin(th)));
        ey_q.push_back(gain * (real'(x) * $sin(th) + real'(y) * $cos(th)));
        ec_q.push_back(cyc);
        tag_q.push_back(tg);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            i_stb = 1'b0;
        end
    endtask

    task automatic drain(input string tg);
        idle(1);
        for (int i = 0; i < 4 * LAT && ex_q.size() != 0; i++) idle(1);
        check({tg, " drain"}, ex_q.size() == 0,
              $sformatf("%0d pending", ex_q.size()), "0 pending");
    endtask

    task automatic test_reset();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            // R1: quiet outputs during reset
            check("R1 valid", o_valid == 1'b0, $sformatf("%0b", o_valid), "0");
            check("R1 data", (o_x == 0) && (o_y == 0),
                  $sformatf("%0d,%0d", o_x, o_y), "0,0");
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first", o_valid == 1'b0, $sformatf("%0b", o_valid), "0");
    endtask

    task automatic test_gain();
        send(20000, 0, 0, "R6");
        send(0, 20000, 0, "R6");
        send(-15000, 0, 0, "R6");
        drain("R6");
    endtask

    task automatic test_quadrants();
        // R7: exact quarter turns
        send(12000, 5000, 16'h0000, "R7");
        send(12000, 5000, 16'h4000, "R7");
        send(12000, 5000, 16'h8000, "R7");
        send(12000, 5000, 16'hC000, "R7");
        // R4: around the eighth-turn rounding points
        send(12000, 5000, 16'h1FFF, "R4");
        send(12000, 5000, 16'h2000, "R4");
        send(12000, 5000, 16'h6000, "R4");
        send(12000, 5000, 16'hE000, "R4");
        send(12000, 5000, 16'hDFFF, "R4");
        drain("R7");
    endtask

    task automatic test_sweep();
        // R3 / R5: phases across the whole turn
        for (int i = 0; i < 48; i++) begin
            send(25000, -9000, (i * 1367 + 11) % 65536, "R3");
            idle(i % 2);
        end
        drain("R3");
    endtask

    task automatic test_extremes();
        // R8: full-scale components at several phases
        send(-32768, -32768, 16'h2000, "R8");
        send(-32768, -32768, 16'hA000, "R8");
        send(32767, 32767, 16'h2000, "R8");
        send(-32768, 32767, 16'h6000, "R8");
        send(32767, -32768, 16'h3456, "R8");
        send(-32768, 0, 16'h8000, "R8");
        drain("R8");
    endtask

    task automatic test_stream();
        // R9: back-to-back samples, then R10: gaps preserved
        for (int i = 0; i < 10; i++) send(3000 * i - 14000, 7000 - 1500 * i, i * 4100, "R9");
        idle(3);
        for (int i = 0; i < 5; i++) begin
            send(9000, 4000 * i - 8000, 60000 - i * 7000, "R10");
            idle(2);
        end
        drain("R9");
        // R10: nothing appears once every sample has left
        for (int i = 0; i < LAT + 2; i++) begin
            @(negedge clk);
            check("R10 quiet", o_valid == 1'b0, $sformatf("%0b", o_valid), "0");
        end
    endtask

    initial begin
        for (int k = 0; k < NSTG; k++) gain = gain * $sqrt(1.0 + 1.0 / real'(1 << (2 * k)));
        test_reset();
        test_gain();
        test_quadrants();
        test_sweep();
        test_extremes();
        test_stream();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule